// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a register-mapped timer with two or three independent 32-bit channels. Each channel has a reload value, a live counter and a 16-bit control word. The control word selects a prescaler, enables the underflow interrupt and holds a sticky underflow flag. A single 8-bit run register holds one run bit per channel, so software starts and stops all channels from one place.

While a channel runs, its counter drops by one on every tick of its own prescaler. When a tick arrives with the counter at zero, the counter reloads from the reload register in that same cycle and the flag is set. The channel's interrupt line is high while both the flag and its enable bit are 1. A periodic interrupt needs only the reload value and one start. For a one-shot delay, software writes the counter directly and keeps the reload value large.

Access is through a simple synchronous port. It accepts byte, halfword and word accesses with right-aligned data at each register's base offset, and read data is valid one cycle after the request.

Top module: `tmr_unit`

## Requirements
- R1: After reset every run bit is 0, every counter and reload register reads 0xFFFFFFFF, every control register reads 0 and every interrupt line is low.
- R2: Run register at offset 4, bit n, controls channel n (1 = counting, 0 = held). A held channel's counter keeps its value, and running one channel leaves the others unchanged.
- R3: Control bits [2:0] set the tick period in clock cycles: 0 = 4, 1 = 16, 2 = 64, 3 = 256, 4 = 1024. With codes 5 to 7 no ticks occur and the counter does not move.
- R4: Each tick decrements the counter by one. A tick that finds the counter at 0 instead loads the reload value in that cycle and sets the flag in control bit 8.
- R5: A channel's interrupt output equals its control bit 8 (flag) AND control bit 5 (enable).
- R6: Writing 0 to control bit 8 clears the flag and writing 1 leaves it unchanged. A byte write to the control register does not touch bit 8. If an underflow and a clear land in the same cycle, the flag stays set.
- R7: The prescaler restarts whenever a channel stops, so the first tick after the run bit is set comes one full period later.
- R8: A software write to the counter takes effect on the next cycle. If it lands in the same cycle as a reload, the written value wins.
- R9: Channel n's reload register is at byte offset 8+12n, its counter at 12+12n and its control at 16+12n. Size 0/1/2 writes the low 8/16/32 bits of the register and keeps the rest. A read returns the register masked to the access size, one cycle later, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Right-aligned write data |
| bus_rdata | output | CNT_W | Read data, valid one cycle after a read request |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The count path is tried with short counter values at the 4-cycle period. The interrupt edge must appear on one exact cycle, which separates an off-by-one in the prescaler from one in the decrement and reload. The 16- and 64-cycle periods are also run, so that a wrong divider code cannot mimic the right one. A reserved code is run for a long time to show that no tick occurs. A stop and restart part-way through a period shows whether the prescaler is cleared. A counter write is timed onto the exact reload cycle to show which source wins. Narrow writes to the control and reload registers, and separate runs of single channels, separate lane masking and channel cross-talk from correct behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W  = 10;
  localparam int CTL_W = 16;
  localparam int SEL_LO = 0;
  localparam int IE_BIT = 5;
  localparam int UF_BIT = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic logic ps_legal(input logic [2:0] sel);
    return sel <= 3'd4;
  endfunction

  // terminal count of the prescaler: (4 << 2*sel) - 1
  function automatic logic [PS_W-1:0] ps_limit(input logic [2:0] sel);
    logic [PS_W:0] span;
    span = (PS_W+1)'(4) << (2 * sel);
    return PS_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] ps_q;

  always_comb tick = run && ps_legal(sel) && (ps_q >= ps_limit(sel));

  always_ff @(posedge clk) begin
    if (rst || !run)          ps_q <= '0;
    else if (tick)            ps_q <= '0;
    else if (ps_legal(sel))   ps_q <= ps_q + 1'b1;
  end

  // R7: a fresh start never ticks on its first running cycle
  p_first_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> !tick);
  // R3: the shortest period is four cycles, so ticks never come back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cnt_we,
  input  logic             rel_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] wr_rel,
  input  logic [CTL_W-1:0] wr_ctl,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rel_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rel_q;
  logic [2:0]       sel_q;
  logic             ie_q, flag_q, tick, underflow;

  tmr_prescaler u_ps (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (sel_q),
    .tick (tick)
  );

  assign underflow = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      rel_q <= '1;
    end else begin
      if (cnt_we)          cnt_q <= wr_cnt;
      else if (underflow)  cnt_q <= rel_q;
      else if (tick)       cnt_q <= cnt_q - 1'b1;
      if (rel_we)          rel_q <= wr_rel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        sel_q <= wr_ctl[SEL_LO +: 3];
        ie_q  <= wr_ctl[IE_BIT];
      end
      if (underflow)                     flag_q <= 1'b1;
      else if (ctl_we && !wr_ctl[UF_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[SEL_LO +: 3] = sel_q;
    ctl_o[IE_BIT]      = ie_q;
    ctl_o[UF_BIT]      = flag_q;
  end
  assign cnt_o = cnt_q;
  assign rel_o = rel_q;
  assign irq_o = flag_q & ie_q;

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    tick && cnt_q == '0 && !cnt_we |=> cnt_q == $past(rel_q));
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    tick && cnt_q == '0 |=> flag_q);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run && !cnt_we |=> $stable(cnt_q));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    flag_q && !(ctl_we && !wr_ctl[UF_BIT]) |=> flag_q);
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(wr_cnt));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int RUN_OFS   = 4;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 12;
  localparam int REL_OFS   = 0;
  localparam int CNT_OFS   = 4;
  localparam int CTL_OFS   = 8;

  logic [NUM_CH-1:0] run_q;
  logic [CNT_W-1:0]  mask, rd_mux;
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [CNT_W-1:0]  rel_a [NUM_CH];
  logic [CTL_W-1:0]  ctl_a [NUM_CH];
  logic              wr, rd, run_hit;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign run_hit = bus_addr == ADDR_W'(RUN_OFS);

  always_comb begin
    unique case (acc_size_e'(bus_size))
      SZ_BYTE: mask = CNT_W'(8'hFF);
      SZ_HALF: mask = CNT_W'(16'hFFFF);
      default: mask = '1;
    endcase
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * i;
    logic hit_rel, hit_cnt, hit_ctl;
    logic [CNT_W-1:0] m_cnt, m_rel, m_ctl;

    assign hit_rel = bus_addr == ADDR_W'(BASE + REL_OFS);
    assign hit_cnt = bus_addr == ADDR_W'(BASE + CNT_OFS);
    assign hit_ctl = bus_addr == ADDR_W'(BASE + CTL_OFS);
    assign m_cnt = (cnt_a[i] & ~mask) | (bus_wdata & mask);
    assign m_rel = (rel_a[i] & ~mask) | (bus_wdata & mask);
    assign m_ctl = (CNT_W'(ctl_a[i]) & ~mask) | (bus_wdata & mask);

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[i]),
      .cnt_we (wr && hit_cnt),
      .rel_we (wr && hit_rel),
      .ctl_we (wr && hit_ctl),
      .wr_cnt (m_cnt),
      .wr_rel (m_rel),
      .wr_ctl (m_ctl[CTL_W-1:0]),
      .cnt_o  (cnt_a[i]),
      .rel_o  (rel_a[i]),
      .ctl_o  (ctl_a[i]),
      .irq_o  (irq[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                 run_q <= '0;
    else if (wr && run_hit)  run_q <= bus_wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (run_hit) rd_mux = CNT_W'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + REL_OFS)) rd_mux = rel_a[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CNT_OFS)) rd_mux = cnt_a[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CTL_OFS)) rd_mux = CNT_W'(ctl_a[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux & mask;
  end

  p_run_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr && run_hit |=> run_q == $past(bus_wdata[NUM_CH-1:0]));
  p_run_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && run_hit) |=> $stable(run_q));
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  localparam int NCH = 3;
  localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;
  localparam logic [5:0] RUN = 6'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_size = 2'd2;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_unit #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(6)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [5:0] a_rel(int n); return 6'(8 + 12*n);  endfunction
  function automatic logic [5:0] a_cnt(int n); return 6'(12 + 12*n); endfunction
  function automatic logic [5:0] a_ctl(int n); return 6'(16 + 12*n); endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [1:0] s, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [1:0] s, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_size = s;
    @(posedge clk); @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic rchk(string req, logic [5:0] a, logic [1:0] s, logic [31:0] exp);
    logic [31:0] d;
    rd(a, s, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    rchk("R1 run", RUN, W, 0);
    for (int n = 0; n < NCH; n++) begin
      rchk("R1 cnt", a_cnt(n), W, 32'hFFFF_FFFF);
      rchk("R1 rel", a_rel(n), W, 32'hFFFF_FFFF);
      rchk("R1 ctl", a_ctl(n), W, 0);
    end
  endtask

  task automatic t_access;
    wr(a_rel(1), W, 32'h1234_5678);
    wr(a_rel(1), B, 32'hFFFF_FFAB);
    rchk("R9 byte write", a_rel(1), W, 32'h1234_56AB);
    wr(a_rel(1), H, 32'h0000_CDEF);
    rchk("R9 half write", a_rel(1), W, 32'h1234_CDEF);
    rchk("R9 byte read", a_rel(1), B, 32'h0000_00EF);
    rchk("R9 half read", a_rel(1), H, 32'h0000_CDEF);
    rchk("R9 unmapped", 6'd60, W, 0);
  endtask

  task automatic t_underflow;
    wr(a_rel(0), W, 5);
    wr(a_cnt(0), W, 3);
    wr(a_ctl(0), H, 16'h0020);
    wr(RUN, B, 1);
    repeat (15) @(negedge clk);
    chk("R4 no underflow before 4th tick", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R4 underflow on 4th tick", 32'(irq[0]), 1);
    wr(RUN, B, 0);
    rchk("R4 reloaded", a_cnt(0), W, 5);
    rchk("R4 flag set", a_ctl(0), H, 32'h0120);
    rchk("R2 run reads back", RUN, W, 0);
  endtask

  task automatic t_gate;
    wr(a_ctl(0), H, 16'h0100);
    chk("R5 enable off masks irq", 32'(irq[0]), 0);
    wr(a_ctl(0), H, 16'h0120);
    chk("R5 enable on drives irq", 32'(irq[0]), 1);
  endtask

  task automatic t_sticky;
    wr(a_ctl(0), B, 32'h0000_0020);
    rchk("R6 byte write keeps flag", a_ctl(0), H, 32'h0120);
    wr(a_ctl(0), H, 16'h0120);
    rchk("R6 writing 1 keeps flag", a_ctl(0), H, 32'h0120);
    wr(a_ctl(0), H, 16'h0020);
    rchk("R6 writing 0 clears flag", a_ctl(0), H, 32'h0020);
    chk("R6 irq after clear", 32'(irq[0]), 0);
  endtask

  task automatic t_prescale;
    wr(a_ctl(0), H, 16'h0021);
    wr(a_cnt(0), W, 1);
    wr(RUN, B, 1);
    repeat (31) @(negedge clk);
    chk("R3 div16 early", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R3 div16 second tick", 32'(irq[0]), 1);
    wr(RUN, B, 0);
    wr(a_ctl(0), H, 16'h0022);
    wr(a_cnt(0), W, 0);
    wr(RUN, B, 1);
    repeat (63) @(negedge clk);
    chk("R3 div64 early", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R3 div64 first tick", 32'(irq[0]), 1);
    wr(RUN, B, 0);
  endtask

  task automatic t_reserved;
    wr(a_ctl(0), H, 16'h0025);
    wr(a_cnt(0), W, 10);
    wr(RUN, B, 1);
    repeat (2000) @(negedge clk);
    wr(RUN, B, 0);
    rchk("R3 reserved code holds count", a_cnt(0), W, 10);
    rchk("R3 reserved code no flag", a_ctl(0), H, 32'h0025);
  endtask

  task automatic t_restart;
    wr(a_ctl(0), H, 16'h0020);
    wr(a_cnt(0), W, 0);
    wr(RUN, B, 1);
    wr(RUN, B, 0);
    wr(RUN, B, 1);
    repeat (3) @(negedge clk);
    chk("R7 no tick before full period", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R7 tick after full period", 32'(irq[0]), 1);
    wr(RUN, B, 0);
  endtask

  task automatic t_sw_wins;
    wr(a_ctl(0), H, 16'h0020);
    wr(a_rel(0), W, 9);
    wr(a_cnt(0), W, 0);
    wr(RUN, B, 1);
    repeat (3) @(negedge clk);
    wr(a_cnt(0), W, 77);
    wr(RUN, B, 0);
    rchk("R8 write beats reload", a_cnt(0), W, 77);
    rchk("R8 underflow still flagged", a_ctl(0), H, 32'h0120);
  endtask

  task automatic t_multi;
    wr(a_ctl(0), H, 16'h0000);
    wr(a_ctl(1), H, 16'h0020);
    wr(a_cnt(1), W, 0);
    wr(a_ctl(2), H, 16'h0020);
    wr(a_cnt(2), W, 0);
    wr(RUN, B, 32'h4);
    repeat (4) @(negedge clk);
    chk("R2 only channel 2 fires", 32'(irq), 32'h4);
    wr(RUN, B, 0);
    rchk("R2 idle channel 1 held", a_cnt(1), W, 0);
    rchk("R2 idle channel 0 held", a_cnt(0), W, 77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_access;
    t_underflow;
    t_gate;
    t_sticky;
    t_prescale;
    t_reserved;
    t_restart;
    t_sw_wins;
    t_multi;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule